// File: doc/BRIEF.md
# Reversible State Permutation Loader

This block holds one reversible n-state inverter: a permutation of the states 0..n-1, stored as a table whose entry i is the image of state i. A host fills a staging copy of the table through a valid/ready write port, one entry per accepted beat. It then starts a commit. During the commit the block walks the staging table one entry per cycle. For each entry it records the matching entry of the reverse table, and it checks that no state is repeated and no value lies outside 0..n-1. Instead of taking host data, the block can also fill the table itself from the affine rule (p*x + q) mod n. It validates that result in the same pass.

When a commit succeeds, the forward and reverse tables become visible on two combinational lookup ports, and the status flag `tbl_ok` is raised. When a commit fails, `tbl_err` is raised and both lookups show the identity mapping. The write port takes back-pressure in one simple way: `wr_ready` is high only while no commit is running. A beat transfers on a clock edge where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low, the host must hold its beat. The number of states n is a parameter of at most 16.

Top module: `perm_inverter_loader`

## Requirements
- R1: After reset, `wr_ready` is 1, `busy`, `done`, `tbl_ok` and `tbl_err` are 0, and both lookups return their index unchanged for every index.
- R2: A beat with `wr_valid` and `wr_ready` both high stores `wr_val` as staging entry `wr_idx`, the image of input state `wr_idx`, and entries may be written in any order. A beat whose `wr_idx` is n or more changes nothing, so after a good commit the forward lookup of that index still returns the index itself.
- R3: A commit started by `load_go` or `gen_go` holds `busy` high for exactly n cycles, with `wr_ready` low during them. `done` is a one-cycle pulse, first high n+1 rising edges after the edge that sampled the start, counting that edge.
- R4: When the staged table holds each state 0..n-1 exactly once, the commit raises `tbl_ok`, the forward lookup returns entry i for input i, and the reverse lookup satisfies rev(fwd(i)) = i. For n=7, the table 1,2,3,4,5,6,0 gives the reverse 6,0,1,2,3,4,5, and the table 2,3,4,0,5,1,6 gives the reverse 3,5,0,1,2,4,6.
- R5: When the staged table holds a state twice, or holds a value of n or more, the commit raises `tbl_err`, clears `tbl_ok`, and both lookups return the identity mapping.
- R6: `gen_go` fills entry x with (p*x + q) mod n from `gen_p` and `gen_q`, each first reduced mod n. It commits that table with the same latency as R3, and a later read shows the generated entries.
- R7: An affine commit whose p is 0 mod n, or shares a factor with n, raises `tbl_err` and leaves the identity mapping on both lookups.
- R8: A lookup index of n or more returns that index unchanged on both lookup ports, whatever has been committed.
- R9: A failed commit removes an earlier good table from the lookups. A later good commit makes a table visible again.
- R10: While a commit runs, `load_go`, `gen_go` and write beats have no effect. If `gen_go` and `load_go` are sampled together, the affine fill is the one that runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host offers a staging entry |
| wr_ready | output | 1 | Block accepts an entry (idle) |
| wr_idx | input | SW | Input state whose image is written |
| wr_val | input | SW | Image value for that state |
| load_go | input | 1 | Start validating the staged table |
| gen_go | input | 1 | Start an affine fill and validation |
| gen_p | input | SW | Affine multiplier |
| gen_q | input | SW | Affine offset |
| busy | output | 1 | Commit in progress |
| done | output | 1 | One-cycle commit-complete pulse |
| tbl_ok | output | 1 | Last commit produced a valid permutation |
| tbl_err | output | 1 | Last commit failed validation |
| fwd_idx | input | SW | Forward lookup input state |
| fwd_val | output | SW | Forward image of `fwd_idx` |
| rev_idx | input | SW | Reverse lookup input state |
| rev_val | output | SW | Reverse image of `rev_idx` |

SW is the number of bits needed to hold n-1 (at least 1).

## Verification
The bound checker watches, on every cycle, that the two committed tables stay inverse to each other. It also checks that a failed commit leaves the identity in place, that `done` is a single pulse closing exactly n busy cycles, that the two status flags never coincide, and that out-of-range forward lookups return their index. Other behaviours can only be shown by the bench scenarios. These are the actual mapping values for both example vectors and for affine rules, the detection of duplicates and out-of-range values, ignored out-of-range writes, the priority of the affine start, and how stimulus applied during a commit is dropped.

// File: rtl/perm_pkg.sv
`timescale 1ns/1ps
package perm_pkg;
  localparam int MAX_STATES = 16;

  typedef enum logic {PH_IDLE, PH_BUILD} phase_t;

  // Bits to hold a state number 0..n-1.
  function automatic int state_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/perm_affine_seq.sv
`timescale 1ns/1ps
// Steps through (p*x + q) mod n for x = 0,1,2,... using one add per step.
module perm_affine_seq #(
  parameter int N_STATES = 7,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [SW-1:0] p_in,
  input  logic [SW-1:0] q_in,
  output logic [SW-1:0] val
);
  localparam logic [SW:0] N_W = (SW+1)'(N_STATES);

  logic [SW-1:0] p_r, acc;
  logic [SW-1:0] p_red, q_red, acc_nx;
  logic [SW:0]   sum;

  // Inputs are below 2^SW < 2n, so one conditional subtract reduces them.
  always_comb begin
    p_red = ({1'b0, p_in} >= N_W) ? SW'({1'b0, p_in} - N_W) : p_in;
    q_red = ({1'b0, q_in} >= N_W) ? SW'({1'b0, q_in} - N_W) : q_in;
    sum   = {1'b0, acc} + {1'b0, p_r};
    acc_nx = (sum >= N_W) ? SW'(sum - N_W) : SW'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_r <= '0;
      acc <= '0;
    end else if (load) begin
      p_r <= p_red;
      acc <= q_red;
    end else if (advance) begin
      acc <= acc_nx;
    end
  end

  assign val = acc;
endmodule

// File: rtl/perm_seen_tracker.sv
`timescale 1ns/1ps
// Records which states have already appeared during a commit pass.
module perm_seen_tracker #(
  parameter int N_STATES = 7,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          mark,
  input  logic [SW-1:0] val,
  output logic          in_range,
  output logic          bad_now,
  output logic          err_acc
);
  localparam int          TBL_D = 1 << SW;
  localparam logic [SW:0] N_W   = (SW+1)'(N_STATES);

  logic [TBL_D-1:0] seen;

  assign in_range = ({1'b0, val} < N_W);
  assign bad_now  = !in_range || seen[val];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= '0;
      err_acc <= 1'b0;
    end else if (clear) begin
      seen    <= '0;
      err_acc <= 1'b0;
    end else if (mark) begin
      if (in_range) seen[val] <= 1'b1;
      err_acc <= err_acc | bad_now;
    end
  end
endmodule

// File: rtl/perm_inverter_loader.sv
`timescale 1ns/1ps
module perm_inverter_loader
  import perm_pkg::*;
#(
  parameter int N_STATES = 7,
  localparam int SW = state_width(N_STATES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [SW-1:0] wr_idx,
  input  logic [SW-1:0] wr_val,
  input  logic          load_go,
  input  logic          gen_go,
  input  logic [SW-1:0] gen_p,
  input  logic [SW-1:0] gen_q,
  output logic          busy,
  output logic          done,
  output logic          tbl_ok,
  output logic          tbl_err,
  input  logic [SW-1:0] fwd_idx,
  output logic [SW-1:0] fwd_val,
  input  logic [SW-1:0] rev_idx,
  output logic [SW-1:0] rev_val
);
  localparam int          TBL_D  = 1 << SW;
  localparam logic [SW:0] N_W    = (SW+1)'(N_STATES);
  localparam logic [SW-1:0] LAST = SW'(N_STATES - 1);

  typedef logic [TBL_D-1:0][SW-1:0] tbl_t;

  function automatic tbl_t ident_tbl();
    tbl_t t;
    for (int i = 0; i < TBL_D; i++) t[i] = SW'(i);
    return t;
  endfunction

  phase_t        phase;
  logic [SW-1:0] step;
  logic          gen_mode;
  tbl_t          stage_inv, stage_rev, act_inv, act_rev;
  tbl_t          inv_nx, rev_nx;
  logic          done_q, ok_q, err_q;

  logic          idle, start, wr_take;
  logic [SW-1:0] aff_val, cur_val;
  logic          cur_in_range, cur_bad, err_acc, final_ok, last_step;

  assign idle     = (phase == PH_IDLE);
  assign start    = idle && (gen_go || load_go);
  assign wr_take  = idle && wr_valid && ({1'b0, wr_idx} < N_W);
  assign last_step = (step == LAST);

  perm_affine_seq #(.N_STATES(N_STATES), .SW(SW)) aff_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (idle && gen_go),
    .advance (!idle),
    .p_in    (gen_p),
    .q_in    (gen_q),
    .val     (aff_val)
  );

  assign cur_val = gen_mode ? aff_val : stage_inv[step];

  perm_seen_tracker #(.N_STATES(N_STATES), .SW(SW)) seen_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .mark     (!idle),
    .val      (cur_val),
    .in_range (cur_in_range),
    .bad_now  (cur_bad),
    .err_acc  (err_acc)
  );

  assign final_ok = !err_acc && !cur_bad;

  // Next staging contents for the current build step.
  always_comb begin
    inv_nx = stage_inv;
    rev_nx = stage_rev;
    inv_nx[step] = cur_val;
    if (cur_in_range) rev_nx[cur_val] = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      step      <= '0;
      gen_mode  <= 1'b0;
      stage_inv <= ident_tbl();
      stage_rev <= ident_tbl();
      act_inv   <= ident_tbl();
      act_rev   <= ident_tbl();
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (wr_take) stage_inv[wr_idx] <= wr_val;
          if (start) begin
            phase     <= PH_BUILD;
            step      <= '0;
            gen_mode  <= gen_go;
            stage_rev <= ident_tbl();
          end
        end
        PH_BUILD: begin
          stage_inv <= inv_nx;
          stage_rev <= rev_nx;
          step      <= step + 1'b1;
          if (last_step) begin
            phase   <= PH_IDLE;
            done_q  <= 1'b1;
            ok_q    <= final_ok;
            err_q   <= !final_ok;
            act_inv <= final_ok ? inv_nx : ident_tbl();
            act_rev <= final_ok ? rev_nx : ident_tbl();
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign wr_ready = idle;
  assign busy     = !idle;
  assign done     = done_q;
  assign tbl_ok   = ok_q;
  assign tbl_err  = err_q;
  assign fwd_val  = act_inv[fwd_idx];
  assign rev_val  = act_rev[rev_idx];
endmodule

// File: rtl/perm_inverter_loader_chk.sv
`timescale 1ns/1ps
module perm_inverter_loader_chk
  import perm_pkg::*;
#(
  parameter int N_STATES = 7,
  localparam int SW = state_width(N_STATES),
  localparam int TBL_D = 1 << SW
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       done,
  input logic                       tbl_ok,
  input logic                       tbl_err,
  input logic [SW-1:0]              fwd_idx,
  input logic [SW-1:0]              fwd_val,
  input logic [TBL_D-1:0][SW-1:0]   act_inv,
  input logic [TBL_D-1:0][SW-1:0]   act_rev
);
  logic [7:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else busy_cnt <= '0;
  end

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == 8'(N_STATES)) && $past(busy));

  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tbl_ok && tbl_err));

  // R8
  fwd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fwd_idx) >= N_STATES) |-> (fwd_val == fwd_idx));

  for (genvar g = 0; g < TBL_D; g++) begin : g_pair
    // R4
    inverse_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_rev[act_inv[g]] == SW'(g));
    // R5
    err_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_err |-> (act_inv[g] == SW'(g)) && (act_rev[g] == SW'(g)));
  end
endmodule

bind perm_inverter_loader perm_inverter_loader_chk #(.N_STATES(N_STATES)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .tbl_ok  (tbl_ok),
  .tbl_err (tbl_err),
  .fwd_idx (fwd_idx),
  .fwd_val (fwd_val),
  .act_inv (act_inv),
  .act_rev (act_rev)
);

// File: tb/perm_inverter_loader_tb.sv
`timescale 1ns/1ps
module perm_inverter_loader_tb_top;
  localparam int N  = 7;
  localparam int SW = 3;
  localparam int TD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [SW-1:0] wr_idx = '0, wr_val = '0;
  logic load_go = 1'b0, gen_go = 1'b0;
  logic [SW-1:0] gen_p = '0, gen_q = '0;
  logic [SW-1:0] fwd_idx = '0, rev_idx = '0;
  logic wr_ready, busy, done, tbl_ok, tbl_err;
  logic [SW-1:0] fwd_val, rev_val;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  int exp_fwd[TD];

  always #4 clk = ~clk;

  perm_inverter_loader #(.N_STATES(N)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_val(wr_val),
    .load_go(load_go), .gen_go(gen_go), .gen_p(gen_p), .gen_q(gen_q),
    .busy(busy), .done(done), .tbl_ok(tbl_ok), .tbl_err(tbl_err),
    .fwd_idx(fwd_idx), .fwd_val(fwd_val), .rev_idx(rev_idx), .rev_val(rev_val)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_ident();
    for (int i = 0; i < TD; i++) exp_fwd[i] = i;
  endtask

  task automatic set_affine(input int p, input int q);
    for (int i = 0; i < TD; i++) exp_fwd[i] = (i < N) ? ((p * i + q) % N) : i;
  endtask

  // Compare both lookup ports against exp_fwd and its inverse.
  task automatic check_tables(input string req);
    int er[TD];
    for (int i = 0; i < TD; i++) er[exp_fwd[i]] = i;
    for (int i = 0; i < TD; i++) begin
      fwd_idx = SW'(i);
      rev_idx = SW'(i);
      #1;
      chk(req, $sformatf("fwd[%0d]", i), int'(fwd_val), exp_fwd[i]);
      chk(req, $sformatf("rev[%0d]", i), int'(rev_val), er[i]);
    end
  endtask

  task automatic write_entry(input int idx, input int val);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_idx = SW'(idx);
    wr_val = SW'(val);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic write_table(input int v[N], input bit reversed);
    for (int k = 0; k < N; k++) begin
      int i;
      i = reversed ? (N - 1 - k) : k;
      write_entry(i, v[i]);
    end
  endtask

  // Start a commit; checks the done latency (R3).
  task automatic run_go(input bit g, input bit l, input int p, input int q);
    int edges;
    edges = 0;
    @(negedge clk);
    gen_go = g;
    load_go = l;
    gen_p = SW'(p);
    gen_q = SW'(q);
    for (int k = 0; k < 64; k++) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (edges == 1) begin
        gen_go = 1'b0;
        load_go = 1'b0;
        chk("R3", "busy after start", int'(busy), 1);
        chk("R3", "wr_ready while busy", int'(wr_ready), 0);
      end
      if (done) break;
    end
    chk("R3", "done latency edges", edges, N + 1);
    @(negedge clk);
    chk("R3", "done is one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "wr_ready", int'(wr_ready), 1);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "tbl_ok", int'(tbl_ok), 0);
    chk("R1", "tbl_err", int'(tbl_err), 0);
    set_ident();
    check_tables("R1");
  endtask

  task automatic t_shift_table();
    int v[N] = '{1, 2, 3, 4, 5, 6, 0};
    int rv[N] = '{6, 0, 1, 2, 3, 4, 5};
    write_table(v, 1'b0);
    run_go(1'b0, 1'b1, 0, 0);
    chk("R4", "tbl_ok", int'(tbl_ok), 1);
    chk("R4", "tbl_err", int'(tbl_err), 0);
    for (int i = 0; i < N; i++) begin
      rev_idx = SW'(i);
      #1;
      chk("R4", $sformatf("literal rev[%0d]", i), int'(rev_val), rv[i]);
    end
    set_ident();
    for (int i = 0; i < N; i++) exp_fwd[i] = v[i];
    check_tables("R4");
  endtask

  task automatic t_mixed_table();
    int v[N] = '{2, 3, 4, 0, 5, 1, 6};
    int rv[N] = '{3, 5, 0, 1, 2, 4, 6};
    write_table(v, 1'b1);
    write_entry(7, 3);  // R2: index beyond n is dropped
    run_go(1'b0, 1'b1, 0, 0);
    chk("R4", "tbl_ok", int'(tbl_ok), 1);
    for (int i = 0; i < N; i++) begin
      rev_idx = SW'(i);
      #1;
      chk("R4", $sformatf("literal rev[%0d]", i), int'(rev_val), rv[i]);
    end
    set_ident();
    for (int i = 0; i < N; i++) exp_fwd[i] = v[i];
    check_tables("R2");
    fwd_idx = 3'd7;
    #1;
    chk("R8", "fwd out of range", int'(fwd_val), 7);
  endtask

  task automatic t_duplicate();
    int v[N] = '{0, 0, 2, 3, 4, 5, 6};
    write_table(v, 1'b0);
    run_go(1'b0, 1'b1, 0, 0);
    chk("R5", "tbl_err dup", int'(tbl_err), 1);
    chk("R5", "tbl_ok dup", int'(tbl_ok), 0);
    set_ident();
    check_tables("R9");
  endtask

  task automatic t_out_of_range();
    int v[N] = '{1, 2, 3, 4, 5, 6, 7};
    write_table(v, 1'b0);
    run_go(1'b0, 1'b1, 0, 0);
    chk("R5", "tbl_err range", int'(tbl_err), 1);
    set_ident();
    check_tables("R5");
  endtask

  task automatic t_affine_good();
    run_go(1'b1, 1'b0, 3, 2);
    chk("R6", "tbl_ok p3 q2", int'(tbl_ok), 1);
    chk("R9", "tbl_err cleared", int'(tbl_err), 0);
    set_affine(3, 2);
    check_tables("R6");
    run_go(1'b1, 1'b0, 5, 7);  // q=7 reduces to 0
    chk("R6", "tbl_ok p5 q7", int'(tbl_ok), 1);
    set_affine(5, 0);
    check_tables("R6");
  endtask

  task automatic t_affine_bad();
    run_go(1'b1, 1'b0, 0, 4);
    chk("R7", "tbl_err p0", int'(tbl_err), 1);
    set_ident();
    check_tables("R7");
    run_go(1'b1, 1'b0, 7, 1);  // p=7 is 0 mod 7
    chk("R7", "tbl_err p7", int'(tbl_err), 1);
    check_tables("R7");
  endtask

  task automatic t_busy_and_priority();
    int dones;
    @(negedge clk);
    gen_go = 1'b1;
    gen_p = 3'd2;
    gen_q = 3'd1;
    @(negedge clk);
    gen_go = 1'b0;
    // Stimulus during the commit must be dropped (R10).
    load_go = 1'b1;
    gen_go = 1'b1;
    gen_p = 3'd0;
    wr_valid = 1'b1;
    wr_idx = 3'd0;
    wr_val = 3'd5;
    chk("R10", "wr_ready low", int'(wr_ready), 0);
    @(negedge clk);
    load_go = 1'b0;
    gen_go = 1'b0;
    wr_valid = 1'b0;
    dones = 0;
    for (int k = 0; k < 3 * N; k++) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R10", "done count", dones, 1);
    chk("R10", "tbl_ok", int'(tbl_ok), 1);
    set_affine(2, 1);
    check_tables("R10");
    // Staging now holds affine(2,1); make it a duplicate, then start both.
    write_entry(0, 0);
    run_go(1'b1, 1'b1, 1, 0);
    chk("R10", "gen wins tbl_ok", int'(tbl_ok), 1);
    set_ident();
    check_tables("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shift_table();
    t_mixed_table();
    t_duplicate();
    t_out_of_range();
    t_affine_good();
    t_affine_bad();
    t_busy_and_priority();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule